// File: doc/BRIEF.md
# NAND Flash Host Bus Sequencer

This block is the host end of an 8-bit multiplexed NAND flash bus. A requester hands it one bus cycle at a time over a valid/ready interface: a command byte, an address byte, a write-data byte, a read-data strobe, or a wait for the device to become ready. The block turns each request into correctly timed levels on the chip-enable, command-latch, address-latch, write-strobe and read-strobe pins. It also drives the shared data lines through an output-enable, so the pad ring can build the bidirectional bus.

The strobe low and high phases are counted in system clocks, so the bus cycle can be set as short as the device allows. Chip enable is held low from the first request of an operation until the request marked last has completed. A wait request ignores the busy line for a programmable settling window. It then waits for the synchronized ready/busy input to read high. Opcode choice, address-cycle count and page sequencing are the requester's job.

Top module: `nand_bus_host`

## Requirements
- R1: After reset, chip enable, write strobe and read strobe are high, both latch enables, the output enable, `done` and `rd_valid` are low, and `req_ready` is high.
- R2: The request kind is a 3-bit code: 0 command, 1 address, 2 write data, 3 read data, 4 wait-ready. A command request drives CLE high, ALE low and the output enable high with the payload on `nand_dq_out`. It holds WE# low for `LO_CYC` cycles and then high for `HI_CYC` cycles, and CLE, ALE and the data stay unchanged through the WE# rising edge.
- R3: An address request (kind 1) gives the same strobe timing with ALE high and CLE low.
- R4: A write-data request (kind 2) gives the same strobe timing with CLE and ALE both low and the output enable high.
- R5: A read request (kind 3) holds RE# low for `LO_CYC` cycles with the output enable low. It samples `nand_dq_in` in the last low cycle and presents it on `rd_byte`, with a one-cycle `rd_valid` pulse that coincides with the RE# rising edge.
- R6: `req_ready` is high in idle and in the final high-phase cycle of a strobe, so that back-to-back strobes have a high phase of exactly `HI_CYC` cycles.
- R7: Chip enable goes low when a request is accepted, stays low across requests not flagged last, and returns high in the cycle after a last-flagged request completes (unless a new request is accepted in that cycle).
- R8: `done` pulses for one cycle when a last-flagged request completes, and stays low for requests not flagged last.
- R9: A wait request ignores `nand_rb_n` for `TWB_CYC` cycles. It then completes once the input, passed through a `SYNC_STAGES` flop synchronizer that resets to the released (high) level, reads high.
- R10: The output enable is low outside command, address and write-data cycles. CLE and ALE are never high together, and WE# and RE# are never low together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted when high with `req_valid` |
| req_kind | input | 3 | Request kind code |
| req_byte | input | 8 | Command, address or write payload |
| req_last | input | 1 | Request closes the operation |
| rd_valid | output | 1 | One-cycle read data strobe |
| rd_byte | output | 8 | Captured read byte |
| done | output | 1 | Last-flagged request completed |
| nand_ce_n | output | 1 | Chip enable, active low |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Write strobe, active low |
| nand_re_n | output | 1 | Read strobe, active low |
| nand_dq_out | output | 8 | Data lines driven by the host |
| nand_dq_oe | output | 1 | Host drive enable for the data lines |
| nand_dq_in | input | 8 | Data lines as seen at the pad |
| nand_rb_n | input | 1 | Ready/busy from the device, low when busy |

## Verification
Accept happens at the clock edge where `req_valid` and `req_ready` are both high. The strobe pin is low during the next `LO_CYC` cycles and high during the `HI_CYC` cycles after that, `rd_valid` falls on the first of those high cycles, and `done` with the chip-enable release lands one cycle later. A wait request completes `max(TWB_CYC+2, r+SYNC_STAGES+1)` cycles after acceptance, where `r` is the cycle in which the bench releases the busy line. The bench drives inputs and samples outputs only on falling edges and steps through these cycle counts one at a time, so every pin is compared against its expected level in every cycle of every request. It sweeps all strobe kinds over many payloads and both last-flag values.

// File: rtl/nbh_pkg.sv
package nbh_pkg;

    localparam int DW = 8;

    typedef enum logic [2:0] {
        K_CMD   = 3'd0,
        K_ADDR  = 3'd1,
        K_WDATA = 3'd2,
        K_RDATA = 3'd3,
        K_WAIT  = 3'd4
    } kind_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_LOW,
        S_HIGH,
        S_TWB,
        S_BUSY
    } state_e;

    typedef struct packed {
        state_e          st;
        logic            ce_n;
        logic            cle;
        logic            ale;
        logic            we_n;
        logic            re_n;
        logic            oe;
        logic [DW-1:0]   dq;
        logic            last;
        kind_e           kind;
        logic            rd_v;
        logic [DW-1:0]   rd_b;
        logic            done;
    } ctl_t;

    localparam ctl_t CTL_RST = '{
        st:   S_IDLE,
        ce_n: 1'b1,
        cle:  1'b0,
        ale:  1'b0,
        we_n: 1'b1,
        re_n: 1'b1,
        oe:   1'b0,
        dq:   '0,
        last: 1'b0,
        kind: K_CMD,
        rd_v: 1'b0,
        rd_b: '0,
        done: 1'b0
    };

endpackage

// File: rtl/nbh_sync.sv
module nbh_sync #(
    parameter int   STAGES    = 2,
    parameter logic RESET_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] sh_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= {STAGES{RESET_VAL}};
        else        sh_q <= {sh_q[STAGES-2:0], din};
    end

    assign dout = sh_q[STAGES-1];
endmodule

// File: rtl/nbh_timer.sv
module nbh_timer #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] val,
    output logic         zero
);
    logic [W-1:0] cnt_q, cnt_d;

    always_comb begin
        cnt_d = cnt_q;
        if (load)              cnt_d = val;
        else if (cnt_q != '0)  cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign zero = (cnt_q == '0);
endmodule

// File: rtl/nand_bus_host.sv
module nand_bus_host
    import nbh_pkg::*;
#(
    parameter int LO_CYC      = 4,
    parameter int HI_CYC      = 4,
    parameter int TWB_CYC     = 25,
    parameter int SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic [2:0]    req_kind,
    input  logic [DW-1:0] req_byte,
    input  logic          req_last,
    output logic          rd_valid,
    output logic [DW-1:0] rd_byte,
    output logic          done,
    output logic          nand_ce_n,
    output logic          nand_cle,
    output logic          nand_ale,
    output logic          nand_we_n,
    output logic          nand_re_n,
    output logic [DW-1:0] nand_dq_out,
    output logic          nand_dq_oe,
    input  logic [DW-1:0] nand_dq_in,
    input  logic          nand_rb_n
);
    localparam int MAX_LH = (LO_CYC > HI_CYC) ? LO_CYC : HI_CYC;
    localparam int MAX_C  = (MAX_LH > TWB_CYC) ? MAX_LH : TWB_CYC;
    localparam int TW     = $clog2(MAX_C + 1);
    localparam logic [TW-1:0] LO_V  = TW'(LO_CYC - 1);
    localparam logic [TW-1:0] HI_V  = TW'(HI_CYC - 1);
    localparam logic [TW-1:0] TWB_V = TW'(TWB_CYC - 1);

    ctl_t          q, d;
    logic          tmr_load, tmr_zero;
    logic [TW-1:0] tmr_val;
    logic          rb_s;
    kind_e         in_kind;

    assign in_kind = kind_e'(req_kind);

    nbh_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_rb_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (nand_rb_n),
        .dout  (rb_s)
    );

    nbh_timer #(.W(TW)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (tmr_load),
        .val   (tmr_val),
        .zero  (tmr_zero)
    );

    always_comb begin
        d         = q;
        d.rd_v    = 1'b0;
        d.done    = 1'b0;
        tmr_load  = 1'b0;
        tmr_val   = '0;
        req_ready = (q.st == S_IDLE) || (q.st == S_HIGH && tmr_zero);

        case (q.st)
            S_LOW: if (tmr_zero) begin
                d.we_n = 1'b1;
                d.re_n = 1'b1;
                if (q.kind == K_RDATA) begin
                    d.rd_v = 1'b1;
                    d.rd_b = nand_dq_in;
                end
                tmr_load = 1'b1;
                tmr_val  = HI_V;
                d.st     = S_HIGH;
            end
            S_HIGH: if (tmr_zero) begin
                d.cle  = 1'b0;
                d.ale  = 1'b0;
                d.oe   = 1'b0;
                d.done = q.last;
                if (q.last) d.ce_n = 1'b1;
                d.st   = S_IDLE;
            end
            S_TWB: if (tmr_zero) d.st = S_BUSY;
            S_BUSY: if (rb_s) begin
                d.done = q.last;
                if (q.last) d.ce_n = 1'b1;
                d.st   = S_IDLE;
            end
            default: ;
        endcase

        if (req_valid && req_ready) begin
            d.ce_n = 1'b0;
            d.kind = in_kind;
            d.last = req_last;
            d.cle  = 1'b0;
            d.ale  = 1'b0;
            d.oe   = 1'b0;
            case (in_kind)
                K_CMD, K_ADDR, K_WDATA: begin
                    d.cle    = (in_kind == K_CMD);
                    d.ale    = (in_kind == K_ADDR);
                    d.oe     = 1'b1;
                    d.dq     = req_byte;
                    d.we_n   = 1'b0;
                    tmr_load = 1'b1;
                    tmr_val  = LO_V;
                    d.st     = S_LOW;
                end
                K_RDATA: begin
                    d.re_n   = 1'b0;
                    tmr_load = 1'b1;
                    tmr_val  = LO_V;
                    d.st     = S_LOW;
                end
                K_WAIT: begin
                    tmr_load = 1'b1;
                    tmr_val  = TWB_V;
                    d.st     = S_TWB;
                end
                default: begin
                    d.done = req_last;
                    d.ce_n = req_last;
                    d.st   = S_IDLE;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= CTL_RST;
        else        q <= d;
    end

    assign rd_valid    = q.rd_v;
    assign rd_byte     = q.rd_b;
    assign done        = q.done;
    assign nand_ce_n   = q.ce_n;
    assign nand_cle    = q.cle;
    assign nand_ale    = q.ale;
    assign nand_we_n   = q.we_n;
    assign nand_re_n   = q.re_n;
    assign nand_dq_out = q.dq;
    assign nand_dq_oe  = q.oe;
endmodule

module nbh_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       rd_valid,
    input logic       nand_ce_n,
    input logic       nand_cle,
    input logic       nand_ale,
    input logic       nand_we_n,
    input logic       nand_re_n,
    input logic [7:0] nand_dq_out,
    input logic       nand_dq_oe
);
    // R10
    latch_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(nand_cle && nand_ale));

    // R10
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(!nand_we_n && !nand_re_n));

    // R10
    no_contention_chk: assert property (@(posedge clk) disable iff (!rst_n)
        nand_dq_oe |-> nand_re_n);

    // R7
    ce_cover_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!nand_we_n || !nand_re_n) |-> !nand_ce_n);

    // R2
    we_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(nand_we_n) |-> ($stable(nand_cle) && $stable(nand_ale)
                              && $stable(nand_dq_out) && nand_dq_oe));

    // R5
    rd_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> (nand_re_n && !$past(nand_re_n)));
endmodule

bind nand_bus_host nbh_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .rd_valid    (rd_valid),
    .nand_ce_n   (nand_ce_n),
    .nand_cle    (nand_cle),
    .nand_ale    (nand_ale),
    .nand_we_n   (nand_we_n),
    .nand_re_n   (nand_re_n),
    .nand_dq_out (nand_dq_out),
    .nand_dq_oe  (nand_dq_oe)
);

// File: tb/tb_nand_bus_host.sv
module tb_nand_bus_host;
    localparam int LO   = 2;
    localparam int HI   = 2;
    localparam int TWB  = 3;
    localparam int SYNC = 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0;
    logic       req_ready;
    logic [2:0] req_kind = 3'd0;
    logic [7:0] req_byte = 8'h00;
    logic       req_last = 1'b0;
    logic       rd_valid;
    logic [7:0] rd_byte;
    logic       done;
    logic       nand_ce_n, nand_cle, nand_ale, nand_we_n, nand_re_n, nand_dq_oe;
    logic [7:0] nand_dq_out, nand_dq_in;
    logic       nand_rb_n = 1'b1;

    int checks = 0;
    int errors = 0;
    int rcol   = 0;
    logic [7:0] mcol = 8'h00;

    always #2 clk = ~clk;

    // device model: read data pattern depends on column, column advances on RE# rise
    assign nand_dq_in = nand_re_n ? 8'h00 : 8'(mcol * 8'd29 + 8'hA5);
    always @(posedge nand_re_n) if (rst_n) mcol <= mcol + 8'd1;

    nand_bus_host #(.LO_CYC(LO), .HI_CYC(HI), .TWB_CYC(TWB), .SYNC_STAGES(SYNC)) dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_kind(req_kind), .req_byte(req_byte), .req_last(req_last),
        .rd_valid(rd_valid), .rd_byte(rd_byte), .done(done),
        .nand_ce_n(nand_ce_n), .nand_cle(nand_cle), .nand_ale(nand_ale),
        .nand_we_n(nand_we_n), .nand_re_n(nand_re_n), .nand_dq_out(nand_dq_out),
        .nand_dq_oe(nand_dq_oe), .nand_dq_in(nand_dq_in), .nand_rb_n(nand_rb_n)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic string ktag(input int k);
        case (k)
            0: return "R2";
            1: return "R3";
            2: return "R4";
            default: return "R5";
        endcase
    endfunction

    task automatic strobe(input int k, input logic [7:0] b, input bit last,
                          input bit aligned, input bit chain);
        bit rd = (k == 3);
        string t = ktag(k);
        if (!aligned) @(negedge clk);
        req_valid = 1'b1; req_kind = 3'(k); req_byte = b; req_last = last;
        @(negedge clk);
        req_valid = 1'b0;
        chk("R6 ready low in low phase", req_ready, 0);
        for (int i = 1; i <= LO; i++) begin
            if (i > 1) @(negedge clk);
            chk({t, " ce low"}, nand_ce_n, 0);
            chk({t, " cle"}, nand_cle, k == 0);
            chk({t, " ale"}, nand_ale, k == 1);
            chk({t, " oe"}, nand_dq_oe, k <= 2);
            if (k <= 2) chk({t, " dq_out"}, nand_dq_out, b);
            chk({t, " we_n low phase"}, nand_we_n, rd);
            chk({t, " re_n low phase"}, nand_re_n, !rd);
        end
        for (int i = 1; i <= HI; i++) begin
            @(negedge clk);
            chk({t, " we_n high phase"}, nand_we_n, 1);
            chk({t, " re_n high phase"}, nand_re_n, 1);
            chk({t, " cle held"}, nand_cle, k == 0);
            chk({t, " ale held"}, nand_ale, k == 1);
            if (rd && i == 1) begin
                chk("R5 rd_valid", rd_valid, 1);
                chk("R5 rd_byte", rd_byte, 8'(rcol * 29 + 8'hA5));
                rcol++;
            end else begin
                chk({t, " rd_valid idle"}, rd_valid, 0);
            end
            chk("R6 ready at last high cycle", req_ready, i == HI);
        end
        if (chain) return;
        @(negedge clk);
        chk("R8 done", done, last);
        chk("R7 ce after request", nand_ce_n, last);
        chk("R10 oe released", nand_dq_oe, 0);
        chk("R10 latches released", {nand_cle, nand_ale}, 0);
        chk("R6 ready idle", req_ready, 1);
    endtask

    task automatic wait_rdy(input bit last, input int low_from, input int low_to);
        int expn = TWB + 2;
        if (low_from >= 0 && low_to + SYNC + 1 > expn) expn = low_to + SYNC + 1;
        @(negedge clk);
        req_valid = 1'b1; req_kind = 3'd4; req_byte = 8'h00; req_last = last;
        nand_rb_n = !(low_from == 0);
        for (int n = 1; n <= expn; n++) begin
            @(negedge clk);
            req_valid = 1'b0;
            nand_rb_n = !(low_from >= 0 && n >= low_from && n < low_to);
            if (n < expn) begin
                chk("R9 done held during wait", done, 0);
                chk("R7 ce low during wait", nand_ce_n, 0);
                chk("R9 ready low during wait", req_ready, 0);
            end else begin
                chk("R9 done at expected cycle", done, last);
                chk("R9 ce after wait", nand_ce_n, last);
            end
        end
        nand_rb_n = 1'b1;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 ce_n", nand_ce_n, 1);
        chk("R1 strobes", {nand_we_n, nand_re_n}, 2'b11);
        chk("R1 latches", {nand_cle, nand_ale}, 0);
        chk("R1 oe", nand_dq_oe, 0);
        chk("R1 ready", req_ready, 1);
        chk("R1 done rd_valid", {done, rd_valid}, 0);

        // sweep over every strobe kind, many payloads, both last values
        for (int k = 0; k < 4; k++)
            for (int bi = 0; bi < 8; bi++)
                strobe(k, 8'(bi * 37 + k * 11), bi[0], 1'b0, 1'b0);

        // R6 back-to-back: next request taken in final high cycle
        strobe(0, 8'h80, 1'b0, 1'b0, 1'b1);
        strobe(1, 8'h12, 1'b0, 1'b1, 1'b1);
        strobe(2, 8'h34, 1'b1, 1'b1, 1'b0);

        // R9 wait: device never busy, busy from start, busy appearing inside tWB
        wait_rdy(1'b1, -1, 0);
        wait_rdy(1'b1, 0, 10);
        wait_rdy(1'b0, 2, 8);
        strobe(3, 8'h00, 1'b1, 1'b0, 1'b0);

        // full page-read style operation, CE# held throughout (R7)
        strobe(0, 8'h00, 1'b0, 1'b0, 1'b0);
        for (int a = 0; a < 5; a++) strobe(1, 8'(a * 3), 1'b0, 1'b0, 1'b0);
        strobe(0, 8'h30, 1'b0, 1'b0, 1'b0);
        wait_rdy(1'b0, 1, 6);
        for (int r = 0; r < 6; r++) strobe(3, 8'h00, r == 5, 1'b0, 1'b0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule